// File: doc/BRIEF.md
# Dual-Buffer Parallel RGB Frame Grabber

This block samples a parallel 24-bit RGB display bus in the panel's own pixel-clock domain. The clock runs at about 10 MHz. The bus carries line and frame sync signals that stay high for several clocks, so each one is reduced to a single rising-edge event. The block counts pixels within each line and lines within each frame. It keeps a rectangular active window and sends only the pixels inside that window to a memory write port. The resulting image is stored row-major, with `ACT_PIX` pixels per row and `ACT_LINES` rows. The defaults are 240 by 320, which gives 76,800 words per buffer.

The block uses two frame buffers. While one buffer is being filled, a downstream reader owns the other one. A frame counts as complete when a frame sync edge arrives and no line-sync timeout occurred since the previous frame sync edge. At that point the block flips its buffer select and raises a one-cycle frame-done strobe, which hands the finished buffer to the reader. After reset, the block writes nothing until it sees the first frame sync edge, so a partial frame is never stored.

The window bounds come from configuration inputs. The block copies them into internal registers on each frame sync edge, so changing them in the middle of a frame does not tear the image. If line sync edges stop arriving during a frame, the block sets a sticky error flag, drops the frame and waits for the next frame sync edge.

Top module: `lcd_frame_grabber`

## Requirements
- R1: While reset is held and right after it, `wr_en`, `frame_done`, `wr_buf` and `sync_err` are all 0.
- R2: A new line starts only on a low-to-high transition of `lcd_hsync`, and a new frame starts only on a low-to-high transition of `lcd_vsync`. Holding either input high for many clocks (for example, `lcd_vsync` high across several lines) starts nothing further.
- R3: From reset until the first rising edge of `lcd_vsync`, no write is issued. That first edge does not toggle `wr_buf` and does not pulse `frame_done`.
- R4: Position numbering works as follows. Sample position p = 0 is the pixel-clock sample in which `lcd_hsync` is first seen high, and p increases by one per clock. Line l = 0 is the first line started after a frame sync edge. A sample is written exactly when start_pix ≤ p < end_pix and start_line ≤ l < end_line, and no sample outside this window (blanking) is written.
- R5: A written sample goes to address (l − start_line)·`ACT_PIX` + (p − start_pix), with its 24 data bits unchanged.
- R6: A sample is also written only when its column is below `ACT_PIX` and its row is below `ACT_LINES`. As a result, `wr_addr` never exceeds `ACT_PIX`·`ACT_LINES` − 1, even when the configured window is larger.
- R7: At a frame sync edge that ends a complete frame, `wr_buf` toggles and `frame_done` is high for exactly one clock. `wr_buf` changes at no other time.
- R8: If a captured frame sees no line sync edge for `HS_TIMEOUT` clocks, `sync_err` goes high and stays high until reset. Writes stop. The next frame sync edge restarts capture without a buffer swap, and the frame after that swaps normally.
- R9: The four window bounds are sampled only on a frame sync edge. Changing the `cfg_*` inputs in the middle of a frame does not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Panel pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| lcd_hsync | input | 1 | Line sync, level-style |
| lcd_vsync | input | 1 | Frame sync, level-style |
| lcd_rgb | input | DATA_W | Pixel data |
| cfg_pix_start | input | CNT_W | First active sample position in a line |
| cfg_pix_end | input | CNT_W | Sample position one past the last active one |
| cfg_line_start | input | CNT_W | First active line index |
| cfg_line_end | input | CNT_W | Line index one past the last active one |
| wr_en | output | 1 | Buffer write strobe |
| wr_addr | output | ADDR_W | Word address within the selected buffer |
| wr_data | output | DATA_W | Pixel word to store |
| wr_buf | output | 1 | Buffer being written; the reader owns the other |
| frame_done | output | 1 | One-clock strobe: the other buffer now holds a full frame |
| sync_err | output | 1 | Sticky flag: line syncs stopped during a frame |

## Verification
A wrong position or line count shows up as a stored image that is shifted or misplaced in its buffer. A level-triggered sync instead of an edge-triggered one shows up as a line counter that keeps clearing, which in turn shows up as a missing or short write count. Both effects become visible within the same frame. A fault in the swap logic shows up at the next frame sync edge: as a missing or doubled `frame_done`, as `wr_buf` pointing at the wrong buffer, or as a swap after a dropped frame. A timeout fault shows up within `HS_TIMEOUT` clocks of a stall, as `sync_err` and the number of writes that were cut off.

// File: rtl/lcd_cap_pkg.sv
package lcd_cap_pkg;

  // Capture controller state: idle waits for a frame sync edge.
  typedef enum logic {
    CAP_IDLE = 1'b0,
    CAP_RUN  = 1'b1
  } cap_state_t;

endpackage

// File: rtl/lcd_sync_edge.sv
// Multi-flop conditioning plus rising-edge detection for level-style syncs.
module lcd_sync_edge #(
  parameter int N_SIG  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SIG-1:0] sig_in,
  output logic [N_SIG-1:0] rise
);

  for (genvar g = 0; g < N_SIG; g++) begin : g_sig
    // sh[STAGES-1] is the conditioned level, sh[STAGES] its previous value
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= {sh[STAGES-1:0], sig_in[g]};
    end

    assign rise[g] = sh[STAGES-1] & ~sh[STAGES];

    // R2: a held level yields one event only
    assert_single_rise_R2: assert property (@(posedge clk) disable iff (rst)
      rise[g] |=> !rise[g]);
  end

endmodule

// File: rtl/lcd_raster_count.sv
// Sample position within a line and line index within a frame.
module lcd_raster_count #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hs_rise,
  input  logic             vs_rise,
  output logic [CNT_W-1:0] pos_q,
  output logic [CNT_W-1:0] line_q,
  output logic             line_ok
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q   <= CNT_MAX;
      line_q  <= '0;
      line_ok <= 1'b0;
    end else begin
      // position saturates so a missing line sync never wraps into the window
      if (hs_rise)               pos_q <= '0;
      else if (pos_q != CNT_MAX) pos_q <= pos_q + 1'b1;

      if (vs_rise) begin
        line_q  <= '0;
        line_ok <= 1'b0;
      end else if (hs_rise) begin
        line_ok <= 1'b1;
        if (!line_ok)               line_q <= '0;
        else if (line_q != CNT_MAX) line_q <= line_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/lcd_cap_ctrl.sv
// Frame-level control: window latch, buffer ping-pong, line-sync watchdog.
module lcd_cap_ctrl
  import lcd_cap_pkg::*;
#(
  parameter int CNT_W      = 10,
  parameter int HS_TIMEOUT = 1024
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hs_rise,
  input  logic             vs_rise,
  input  logic [CNT_W-1:0] cfg_pix_start,
  input  logic [CNT_W-1:0] cfg_pix_end,
  input  logic [CNT_W-1:0] cfg_line_start,
  input  logic [CNT_W-1:0] cfg_line_end,
  output logic             capturing,
  output logic             wr_buf,
  output logic             frame_done,
  output logic             err,
  output logic [CNT_W-1:0] win_ps,
  output logic [CNT_W-1:0] win_pe,
  output logic [CNT_W-1:0] win_ls,
  output logic [CNT_W-1:0] win_le
);

  localparam int GAP_W = $clog2(HS_TIMEOUT + 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(HS_TIMEOUT - 1);

  cap_state_t       state;
  logic [GAP_W-1:0] gap_q;

  assign capturing = (state == CAP_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= CAP_IDLE;
      gap_q      <= '0;
      wr_buf     <= 1'b0;
      frame_done <= 1'b0;
      err        <= 1'b0;
      win_ps     <= '0;
      win_pe     <= '0;
      win_ls     <= '0;
      win_le     <= '0;
    end else begin
      frame_done <= 1'b0;
      if (vs_rise) begin
        win_ps <= cfg_pix_start;
        win_pe <= cfg_pix_end;
        win_ls <= cfg_line_start;
        win_le <= cfg_line_end;
        gap_q  <= '0;
        if (state == CAP_RUN) begin
          wr_buf     <= ~wr_buf;
          frame_done <= 1'b1;
        end
        state <= CAP_RUN;
      end else if (state == CAP_RUN) begin
        if (hs_rise) begin
          gap_q <= '0;
        end else if (gap_q == GAP_LAST) begin
          err   <= 1'b1;
          state <= CAP_IDLE;
          gap_q <= '0;
        end else begin
          gap_q <= gap_q + 1'b1;
        end
      end
    end
  end

  // R7: every strobe comes with a buffer flip
  assert_done_swaps_R7: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (wr_buf != $past(wr_buf)));

  // R7: the buffer select never moves without a strobe
  assert_swap_needs_done_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_buf != $past(wr_buf)) |-> frame_done);

  // R7: strobe lasts one clock
  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  // R8: error flag is sticky
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    $past(err) |-> err);

endmodule

// File: rtl/lcd_frame_grabber.sv
module lcd_frame_grabber #(
  parameter int DATA_W      = 24,
  parameter int ACT_PIX     = 240,
  parameter int ACT_LINES   = 320,
  parameter int CNT_W       = 10,
  parameter int SYNC_STAGES = 2,
  parameter int HS_TIMEOUT  = 1024,
  localparam int DEPTH      = ACT_PIX * ACT_LINES,
  localparam int ADDR_W     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lcd_hsync,
  input  logic              lcd_vsync,
  input  logic [DATA_W-1:0] lcd_rgb,
  input  logic [CNT_W-1:0]  cfg_pix_start,
  input  logic [CNT_W-1:0]  cfg_pix_end,
  input  logic [CNT_W-1:0]  cfg_line_start,
  input  logic [CNT_W-1:0]  cfg_line_end,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_buf,
  output logic              frame_done,
  output logic              sync_err
);

  // data travels one stage past the sync conditioning, matching the counters
  localparam int DLY = SYNC_STAGES + 1;

  logic [1:0]        sync_rise;
  logic              hs_rise, vs_rise;
  logic [CNT_W-1:0]  pos_q, line_q;
  logic              line_ok, capturing;
  logic [CNT_W-1:0]  win_ps, win_pe, win_ls, win_le;
  logic [DATA_W-1:0] dpipe [DLY];

  lcd_sync_edge #(.N_SIG(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .sig_in ({lcd_vsync, lcd_hsync}),
    .rise   (sync_rise)
  );
  assign hs_rise = sync_rise[0];
  assign vs_rise = sync_rise[1];

  for (genvar g = 0; g < DLY; g++) begin : g_dly
    always_ff @(posedge clk) begin
      if (g == 0) dpipe[g] <= lcd_rgb;
      else        dpipe[g] <= dpipe[(g == 0) ? 0 : g-1];
    end
  end

  lcd_raster_count #(.CNT_W(CNT_W)) u_count (
    .clk     (clk),
    .rst     (rst),
    .hs_rise (hs_rise),
    .vs_rise (vs_rise),
    .pos_q   (pos_q),
    .line_q  (line_q),
    .line_ok (line_ok)
  );

  lcd_cap_ctrl #(.CNT_W(CNT_W), .HS_TIMEOUT(HS_TIMEOUT)) u_ctrl (
    .clk            (clk),
    .rst            (rst),
    .hs_rise        (hs_rise),
    .vs_rise        (vs_rise),
    .cfg_pix_start  (cfg_pix_start),
    .cfg_pix_end    (cfg_pix_end),
    .cfg_line_start (cfg_line_start),
    .cfg_line_end   (cfg_line_end),
    .capturing      (capturing),
    .wr_buf         (wr_buf),
    .frame_done     (frame_done),
    .err            (sync_err),
    .win_ps         (win_ps),
    .win_pe         (win_pe),
    .win_ls         (win_ls),
    .win_le         (win_le)
  );

  // window test and linear address for the sample aligned with the counters
  logic [CNT_W-1:0]  col, row;
  logic              in_win;
  logic [ADDR_W-1:0] lin_addr;

  always_comb begin
    col    = pos_q - win_ps;
    row    = line_q - win_ls;
    in_win = capturing && line_ok &&
             (pos_q >= win_ps) && (pos_q < win_pe) &&
             (line_q >= win_ls) && (line_q < win_le) &&
             (32'(col) < 32'(ACT_PIX)) && (32'(row) < 32'(ACT_LINES));
    lin_addr = ADDR_W'(row) * ADDR_W'(ACT_PIX) + ADDR_W'(col);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en   <= in_win;
      wr_addr <= lin_addr;
      wr_data <= dpipe[DLY-1];
    end
  end

  // R6: address stays inside one buffer
  assert_addr_range_R6: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (32'(wr_addr) < 32'(DEPTH)));

  // R3: writes only follow a cycle in which capture was running
  assert_write_in_capture_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(capturing));

endmodule

// File: tb/lcd_frame_grabber_tb.sv
`timescale 1ns/1ps
module lcd_frame_grabber_tb;

  localparam int CLK_P    = 100;
  localparam int DW       = 24;
  localparam int PIX      = 8;
  localparam int LINES    = 6;
  localparam int CW       = 10;
  localparam int TMO      = 64;
  localparam int DEPTH    = PIX * LINES;
  localparam int AW       = $clog2(DEPTH);
  localparam int LINE_LEN = 20;
  localparam int FR_LINES = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hs = 1'b0, vs = 1'b0;
  logic [DW-1:0] rgb = '0;
  logic [CW-1:0] c_ps = 10'd4, c_pe = 10'd12, c_ls = 10'd2, c_le = 10'd8;
  logic          wr_en, wr_buf, frame_done, sync_err;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  always #(CLK_P/2) clk = ~clk;

  lcd_frame_grabber #(
    .DATA_W(DW), .ACT_PIX(PIX), .ACT_LINES(LINES), .CNT_W(CW),
    .SYNC_STAGES(2), .HS_TIMEOUT(TMO)
  ) u_dut (
    .clk(clk), .rst(rst), .lcd_hsync(hs), .lcd_vsync(vs), .lcd_rgb(rgb),
    .cfg_pix_start(c_ps), .cfg_pix_end(c_pe),
    .cfg_line_start(c_ls), .cfg_line_end(c_le),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_buf(wr_buf), .frame_done(frame_done), .sync_err(sync_err)
  );

  int n_chk = 0, n_fail = 0;
  int wr_cnt [2] = '{0, 0};
  int done_cnt = 0, bad_addr = 0, vs_left = 0;
  bit finished = 0;
  logic [DW-1:0] bmem [2][DEPTH];

  // write-port monitor, sampled at the inactive edge
  always @(negedge clk) begin
    if (!rst) begin
      if (wr_en) begin
        if (int'(wr_addr) >= DEPTH) bad_addr++;
        else bmem[wr_buf][int'(wr_addr)] = wr_data;
        wr_cnt[wr_buf]++;
      end
      if (frame_done) done_cnt++;
    end
  end

  function automatic logic [DW-1:0] pat(int id, int l, int p);
    return {8'(id), 8'(l), 8'(p)};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(logic h, logic [DW-1:0] d);
    @(posedge clk);
    #(CLK_P/4);
    hs  = h;
    rgb = d;
    if (vs_left > 0) begin vs = 1'b1; vs_left--; end
    else vs = 1'b0;
  endtask

  task automatic send_line(int id, int l);
    for (int p = 0; p < LINE_LEN; p++) tick(p < 2, pat(id, l, p));
  endtask

  // vsync held vs_len clocks; optional stall before line stall_at;
  // optional switch to the oversize window at line cfg_at
  task automatic send_frame(int id, int vs_len, int stall_at, int cfg_at);
    vs_left = vs_len;
    repeat (4) tick(1'b0, '0);
    for (int l = 0; l < FR_LINES; l++) begin
      if (l == stall_at) repeat (100) tick(1'b0, '0);
      if (l == cfg_at) begin
        c_ps = 10'd2; c_pe = 10'd20; c_ls = 10'd1; c_le = 10'd10;
      end
      send_line(id, l);
    end
  endtask

  task automatic clear_buf(int b);
    for (int i = 0; i < DEPTH; i++) bmem[b][i] = 24'hEEEEEE;
  endtask

  task automatic check_buf(int b, int id, int ps, int ls, string req);
    int bad = 0;
    for (int r = 0; r < LINES; r++)
      for (int c = 0; c < PIX; c++)
        if (bmem[b][r*PIX + c] !== pat(id, r + ls, c + ps)) bad++;
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic t_reset();
    chk(wr_en == 1'b0, "R1 wr_en", int'(wr_en), 0);
    chk(frame_done == 1'b0, "R1 frame_done", int'(frame_done), 0);
    chk(wr_buf == 1'b0, "R1 wr_buf", int'(wr_buf), 0);
    chk(sync_err == 1'b0, "R1 sync_err", int'(sync_err), 0);
  endtask

  task automatic t_partial();
    int w0 = wr_cnt[0] + wr_cnt[1];
    for (int l = 0; l < 5; l++) send_line(9, l);
    chk(wr_cnt[0] + wr_cnt[1] == w0, "R3 no write before vsync", wr_cnt[0] + wr_cnt[1] - w0, 0);
  endtask

  task automatic t_first_frame();
    int w0 = wr_cnt[0], w1 = wr_cnt[1];
    clear_buf(0); clear_buf(1);
    send_frame(1, 30, -1, -1);
    chk(done_cnt == 0, "R3 first vsync no strobe", done_cnt, 0);
    chk(wr_buf == 1'b0, "R3 first vsync no swap", int'(wr_buf), 0);
    chk(wr_cnt[0] - w0 == DEPTH, "R4 write count", wr_cnt[0] - w0, DEPTH);
    chk(wr_cnt[1] == w1, "R4 other buffer untouched", wr_cnt[1] - w1, 0);
    check_buf(0, 1, 4, 2, "R5 frame 1 image");
  endtask

  task automatic t_long_vsync();
    int w1 = wr_cnt[1];
    send_frame(2, 150, -1, -1);
    chk(done_cnt == 1, "R7 strobe count", done_cnt, 1);
    chk(wr_buf == 1'b1, "R7 swapped", int'(wr_buf), 1);
    chk(wr_cnt[1] - w1 == DEPTH, "R2 long vsync full frame", wr_cnt[1] - w1, DEPTH);
    check_buf(1, 2, 4, 2, "R2 long vsync image");
  endtask

  task automatic t_cfg_latch();
    int w0 = wr_cnt[0];
    clear_buf(0);
    send_frame(3, 30, -1, 3);
    chk(done_cnt == 2 && wr_buf == 1'b0, "R7 second swap", done_cnt, 2);
    chk(wr_cnt[0] - w0 == DEPTH, "R9 count", wr_cnt[0] - w0, DEPTH);
    check_buf(0, 3, 4, 2, "R9 mid-frame cfg ignored");
  endtask

  task automatic t_oversize();
    int w1 = wr_cnt[1];
    clear_buf(1);
    send_frame(4, 30, -1, -1);
    chk(wr_buf == 1'b1, "R7 third swap", int'(wr_buf), 1);
    chk(wr_cnt[1] - w1 == DEPTH, "R6 clipped count", wr_cnt[1] - w1, DEPTH);
    chk(bad_addr == 0, "R6 address range", bad_addr, 0);
    check_buf(1, 4, 2, 1, "R6 clipped image");
  endtask

  task automatic t_timeout();
    int w0 = wr_cnt[0];
    clear_buf(0);
    send_frame(5, 30, 3, -1);
    chk(done_cnt == 4 && wr_buf == 1'b0, "R8 frame 4 completed", done_cnt, 4);
    chk(sync_err == 1'b1, "R8 error raised", int'(sync_err), 1);
    chk(wr_cnt[0] - w0 == 2*PIX, "R8 writes stop", wr_cnt[0] - w0, 2*PIX);
    w0 = wr_cnt[0];
    clear_buf(0);
    send_frame(6, 30, -1, -1);
    chk(done_cnt == 4, "R8 dropped frame no strobe", done_cnt, 4);
    chk(wr_buf == 1'b0, "R8 dropped frame no swap", int'(wr_buf), 0);
    chk(wr_cnt[0] - w0 == DEPTH, "R8 capture resumes", wr_cnt[0] - w0, DEPTH);
    send_frame(7, 30, -1, -1);
    chk(done_cnt == 5 && wr_buf == 1'b1, "R8 swap after resync", done_cnt, 5);
    chk(sync_err == 1'b1, "R8 error sticky", int'(sync_err), 1);
    check_buf(0, 6, 2, 1, "R8 resynced image");
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #(CLK_P/4);
    t_reset();
    rst = 1'b0;
    tick(1'b0, '0);
    t_reset();
    t_partial();
    t_first_frame();
    t_long_vsync();
    t_cfg_latch();
    t_oversize();
    t_timeout();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule